// File: doc/BRIEF.md
# Bit-Addressable GPIO Port Register File

This block is one 8-bit general-purpose I/O port as seen from a byte-wide register bus. Each pin has its own direction bit, output value bit and pull-up enable bit, all held in separate registers, and the live pin levels can be read back through a synchronizer. The bus has an address, a write strobe, a read strobe, write data and combinational read data.

Next to the bus there is a single-bit command path. It carries an address, a 3-bit bit index and a set/clear selector. It changes exactly one bit of one register and leaves the other seven bits alone. Only the low address window (below 0x20) accepts these commands. One status register holds a pin-change flag that is cleared by writing a one to it. Because a bit command writes only the addressed bit, a set command on that flag clears the flag and nothing else.

The flag is driven by a two-state machine. In state `FLG_IDLE` the flag reads 0. The transition *detect* goes from `FLG_IDLE` to `FLG_SET` when the synchronized pin value differs from its value one clock earlier. In state `FLG_SET` the flag reads 1. The transition *acknowledge* goes from `FLG_SET` back to `FLG_IDLE` when a clear arrives and no new change is seen in the same cycle. In every other case the machine stays in its state (*hold*).

Register map: 0x00 pin levels (read-only), 0x01 direction, 0x02 output value, 0x03 status (bit 0 is the change flag, bits 7:1 always read 0), 0x21 pull-up enable. All other addresses are reserved.

Top module: `gpio_port`

## Requirements
- R1: When `rst_n` goes low, the direction, output and pull-up registers clear to zero and `pin_oe` goes to zero at once, without waiting for a clock edge.
- R2: `pin_oe[i]` equals direction bit i. `pin_out` equals the output-value register. `pin_pullup[i]` is 1 only when direction bit i is 0 and pull-up bit i is 1.
- R3: A bus write to 0x01 (direction), 0x02 (output) or 0x21 (pull-up) loads the whole byte at the next clock edge. While `bus_rd` is high, `bus_rdata` returns the addressed register in the same cycle.
- R4: Address 0x00 returns `pin_in` through a two-flop synchronizer. A change on `pin_in` becomes visible after the second rising edge that follows it. Bus writes to 0x00 have no effect.
- R5: A bit command (`bop_en` high) to an address below 0x20 sets bit `bop_idx` when `bop_val` is 1 and clears it when `bop_val` is 0. The change takes effect at the next edge, and the other bits keep their values.
- R6: A bit command to an address of 0x20 or above, such as the pull-up register at 0x21, changes nothing.
- R7: If a bus write and a bit command target the same address in the same cycle, the bus write wins and the bit command is dropped. If they target different addresses, both take effect.
- R8: The change flag (0x03 bit 0, also on `flag_chg`) goes to 1 three rising edges after `pin_in` changes. It stays at 1 until it is cleared.
- R9: The flag clears on a bus write to 0x03 with data bit 0 = 1, or on a set command to 0x03 with index 0. A bus write with data bit 0 = 0, a clear command, or a set command with a nonzero index leaves the flag at 1. If a clear and a new pin change fall in the same cycle, the flag stays at 1.
- R10: Reserved addresses, and bits 7:1 of 0x03, read as zero. Writes to reserved addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (zero when `bus_rd` is low) |
| bop_en | input | 1 | Bit command valid |
| bop_val | input | 1 | Bit command: 1 sets the bit, 0 clears it |
| bop_addr | input | 8 | Bit command target address |
| bop_idx | input | 3 | Bit command bit index |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven value |
| pin_pullup | output | 8 | Per-pin weak pull-up enable |
| flag_chg | output | 1 | Pin-change flag |

## Verification
The bit-command path is driven with set and clear commands on different bit positions of the direction and output registers. These show that only one bit moves. The same commands are sent to the pull-up register above the window, where nothing may change. Bus writes and bit commands are issued in the same cycle, once to the same address and once to different addresses, which separates the "bus wins" rule from a blanket drop of the bit command. The flag is cleared with each variant of write and bit command, so the clearing forms can be told apart from the forms that must not clear. The pin-read register and the flag are sampled cycle by cycle after a pin change, which fixes the synchronizer depth. A clear is placed in the same cycle as a detected change to fix the priority between the two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_SET  = 1'b1
    } flg_state_e;

    function automatic logic [7:0] unused_pad8();
        return 8'h00;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= stg[k-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_reg_update.sv
module gpio_reg_update #(
    parameter int              W     = 8,
    parameter int              AW    = 8,
    parameter int              IDX_W = 3,
    parameter logic [AW-1:0]   ADDR  = '0,
    parameter int              LIMIT = 32
) (
    input  logic [W-1:0]     cur_i,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [W-1:0]     bus_wdata,
    input  logic             bop_en,
    input  logic             bop_val,
    input  logic [AW-1:0]    bop_addr,
    input  logic [IDX_W-1:0] bop_idx,
    output logic [W-1:0]     nxt_o
);
    localparam bit BIT_OK = (int'(ADDR) < LIMIT);

    logic [W-1:0] mask;
    logic         bus_hit;
    logic         bop_hit;

    assign mask    = {{(W-1){1'b0}}, 1'b1} << bop_idx;
    assign bus_hit = bus_wr && (bus_addr == ADDR);
    assign bop_hit = BIT_OK && bop_en && (bop_addr == ADDR);

    always_comb begin
        if (bus_hit)       nxt_o = bus_wdata;
        else if (bop_hit)  nxt_o = bop_val ? (cur_i | mask) : (cur_i & ~mask);
        else               nxt_o = cur_i;
    end
endmodule

// File: rtl/gpio_chg_fsm.sv
module gpio_chg_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic clr_i,
    output logic flag_o
);
    flg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (chg_i)           state_d = FLG_SET;
            FLG_SET:  if (clr_i && !chg_i) state_d = FLG_IDLE;
            default:                       state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb flag_o = (state_q == FLG_SET);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_SET && !clr_i) |=> (state_q == FLG_SET));

    assert_flag_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> flag_o);
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int            W         = 8,
    parameter int            AW        = 8,
    parameter int            SYNC_LEN  = 2,
    parameter int            BIT_LIMIT = 32,
    parameter logic [AW-1:0] A_PIN     = 8'h00,
    parameter logic [AW-1:0] A_DIR     = 8'h01,
    parameter logic [AW-1:0] A_OUT     = 8'h02,
    parameter logic [AW-1:0] A_FLAG    = 8'h03,
    parameter logic [AW-1:0] A_PULL    = 8'h21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [W-1:0]          bus_wdata,
    output logic [W-1:0]          bus_rdata,
    input  logic                  bop_en,
    input  logic                  bop_val,
    input  logic [AW-1:0]         bop_addr,
    input  logic [$clog2(W)-1:0]  bop_idx,
    input  logic [W-1:0]          pin_in,
    output logic [W-1:0]          pin_oe,
    output logic [W-1:0]          pin_out,
    output logic [W-1:0]          pin_pullup,
    output logic                  flag_chg
);
    localparam int IDX_W  = $clog2(W);
    localparam int N_REGS = 3;
    localparam bit FLAG_BIT_OK = (int'(A_FLAG) < BIT_LIMIT);

    logic [W-1:0] reg_q [N_REGS];
    logic [W-1:0] reg_d [N_REGS];
    logic [W-1:0] dir_q, out_q, pull_q;
    logic [W-1:0] pin_sync, pin_prev_q;
    logic         chg, flag_clr, bus_flag_hit;

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        localparam logic [AW-1:0] RA = (i == 0) ? A_DIR : ((i == 1) ? A_OUT : A_PULL);

        gpio_reg_update #(
            .W(W), .AW(AW), .IDX_W(IDX_W), .ADDR(RA), .LIMIT(BIT_LIMIT)
        ) u_upd (
            .cur_i    (reg_q[i]),
            .bus_wr   (bus_wr),
            .bus_addr (bus_addr),
            .bus_wdata(bus_wdata),
            .bop_en   (bop_en),
            .bop_val  (bop_val),
            .bop_addr (bop_addr),
            .bop_idx  (bop_idx),
            .nxt_o    (reg_d[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q[i] <= '0;
            else        reg_q[i] <= reg_d[i];
        end
    end

    assign dir_q  = reg_q[0];
    assign out_q  = reg_q[1];
    assign pull_q = reg_q[2];

    gpio_pin_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pin_in),
        .q_o  (pin_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev_q <= '0;
        else        pin_prev_q <= pin_sync;
    end

    assign chg          = (pin_sync != pin_prev_q);
    assign bus_flag_hit = bus_wr && (bus_addr == A_FLAG);
    assign flag_clr     = (bus_flag_hit && bus_wdata[0])
                        || (FLAG_BIT_OK && !bus_flag_hit && bop_en && bop_val
                            && (bop_addr == A_FLAG) && (bop_idx == '0));

    gpio_chg_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .chg_i (chg),
        .clr_i (flag_clr),
        .flag_o(flag_chg)
    );

    assign pin_oe     = dir_q & {W{rst_n}};
    assign pin_out    = out_q;
    assign pin_pullup = pull_q & ~dir_q & {W{rst_n}};

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if      (bus_addr == A_PIN)  bus_rdata = pin_sync;
            else if (bus_addr == A_DIR)  bus_rdata = dir_q;
            else if (bus_addr == A_OUT)  bus_rdata = out_q;
            else if (bus_addr == A_FLAG) bus_rdata = {{(W-1){1'b0}}, flag_chg};
            else if (bus_addr == A_PULL) bus_rdata = pull_q;
        end
    end

    assert_bop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bop_en && bop_addr == A_DIR && !(bus_wr && bus_addr == A_DIR))
        |=> ($countones(dir_q ^ $past(dir_q)) <= 1));

    assert_bop_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(A_PULL) >= BIT_LIMIT && bop_en && bop_addr == A_PULL
         && !(bus_wr && bus_addr == A_PULL))
        |=> $stable(pull_q));

    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != A_PIN && bus_addr != A_DIR && bus_addr != A_OUT
         && bus_addr != A_FLAG && bus_addr != A_PULL) |-> (bus_rdata == '0));

    assert_bus_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OUT && bop_en && bop_addr == A_OUT)
        |=> (out_q == $past(bus_wdata)));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bop_en = 1'b0;
    logic       bop_val = 1'b0;
    logic [7:0] bop_addr = '0;
    logic [2:0] bop_idx = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe, pin_out, pin_pullup;
    logic       flag_chg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bop_en(bop_en), .bop_val(bop_val), .bop_addr(bop_addr), .bop_idx(bop_idx),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .pin_pullup(pin_pullup), .flag_chg(flag_chg)
    );

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = pin_oe;
                2: act = pin_out;
                3: act = pin_pullup;
                default: act = {7'd0, flag_chg};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int kind, input logic [7:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle_drive();
        bus_wr = 1'b0; bus_rd = 1'b0; bop_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1; idle_drive();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1; idle_drive();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic bop(input logic [7:0] a, input logic [2:0] idx, input logic v);
        @(posedge clk); #1; idle_drive();
        bop_en = 1'b1; bop_addr = a; bop_idx = idx; bop_val = v;
    endtask

    task automatic wr_bop(input logic [7:0] a, input logic [7:0] d,
                          input logic [7:0] ba, input logic [2:0] idx, input logic v);
        @(posedge clk); #1; idle_drive();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        bop_en = 1'b1; bop_addr = ba; bop_idx = idx; bop_val = v;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1; idle_drive();
        bus_rd = 1'b1; bus_addr = a;
        expect_item(0, e, tag);
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(posedge clk); #1; idle_drive();
        pin_in = v;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h01, 8'h00, "R1 dir reset");
        rd(8'h02, 8'h00, "R1 out reset");
        rd(8'h21, 8'h00, "R1 pull reset");
        expect_item(1, 8'h00, "R1 oe reset");
        rd(8'h03, 8'h00, "R8 flag idle after reset");

        // R3 full-byte writes, R2 pin drive
        wr(8'h01, 8'hF0);
        wr(8'h02, 8'hA5);
        wr(8'h21, 8'h3C);
        rd(8'h01, 8'hF0, "R3 dir readback");
        rd(8'h02, 8'hA5, "R3 out readback");
        rd(8'h21, 8'h3C, "R3 pull readback");
        expect_item(1, 8'hF0, "R2 oe from dir");
        expect_item(2, 8'hA5, "R2 out value");
        expect_item(3, 8'h0C, "R2 pullup only on inputs");

        // R5 bit commands inside the window
        bop(8'h01, 3'd1, 1'b1);
        rd(8'h01, 8'hF2, "R5 set dir bit1");
        bop(8'h01, 3'd7, 1'b0);
        rd(8'h01, 8'h72, "R5 clear dir bit7");
        bop(8'h02, 3'd6, 1'b1);
        rd(8'h02, 8'hE5, "R5 set out bit6");
        expect_item(2, 8'hE5, "R5 out pins");

        // R6 bit commands above the window ignored
        bop(8'h21, 3'd0, 1'b1);
        bop(8'h21, 3'd2, 1'b0);
        rd(8'h21, 8'h3C, "R6 pull untouched");
        expect_item(3, 8'h0C, "R6 pullup pins untouched");

        // R7 bus write beats bit command on the same address
        wr_bop(8'h01, 8'h0F, 8'h01, 3'd7, 1'b1);
        rd(8'h01, 8'h0F, "R7 same address bus wins");
        wr_bop(8'h02, 8'h11, 8'h01, 3'd0, 1'b0);
        rd(8'h02, 8'h11, "R7 different address bus part");
        rd(8'h01, 8'h0E, "R7 different address bit part");

        // R10 reserved addresses
        wr(8'h05, 8'hFF);
        rd(8'h05, 8'h00, "R10 reserved reads zero");
        rd(8'h01, 8'h0E, "R10 reserved write no side effect");

        // R4 synchronizer lag, R8 flag timing
        set_pins(8'h5A);
        rd(8'h00, 8'h00, "R4 one edge after change");
        rd(8'h03, 8'h00, "R8 flag two edges after change");
        rd(8'h03, 8'h01, "R8 flag three edges after change");
        rd(8'h00, 8'h5A, "R4 pins visible");
        wr(8'h00, 8'hFF);
        rd(8'h00, 8'h5A, "R4 write to pin register ignored");

        // R9 clearing variants
        wr(8'h03, 8'hFE);
        rd(8'h03, 8'h01, "R9 write zero bit0 keeps flag");
        bop(8'h03, 3'd0, 1'b0);
        rd(8'h03, 8'h01, "R9 clear command keeps flag");
        bop(8'h03, 3'd3, 1'b1);
        rd(8'h03, 8'h01, "R9 set other index keeps flag");
        wr(8'h03, 8'h01);
        rd(8'h03, 8'h00, "R9 write one clears");
        expect_item(4, 8'h00, "R9 flag pin cleared");

        set_pins(8'hA5);
        tick(); tick();
        rd(8'h03, 8'h01, "R8 flag set again");
        bop(8'h03, 3'd0, 1'b1);
        rd(8'h03, 8'h00, "R9 set command clears only flag");
        rd(8'h01, 8'h0E, "R9 set command leaves dir");

        // R9 clear and change in the same cycle: flag must survive
        wr(8'h02, 8'h11);
        set_pins(8'h00);
        tick();
        tick();
        rd(8'h03, 8'h01, "R9 flag set before collision");
        set_pins(8'hFF);
        tick();
        wr(8'h03, 8'h01);
        rd(8'h03, 8'h01, "R9 change beats clear");

        // R1 asynchronous reset in mid-run
        wr(8'h01, 8'hFF);
        tick();
        expect_item(1, 8'hFF, "R1 oe before reset");
        @(posedge clk); #1; idle_drive();
        rst_n = 1'b0;
        #1;
        if (pin_oe !== 8'h00) begin
            n_fail++;
            $display("FAIL R1 async oe: actual %02h expected 00", pin_oe);
        end
        n_checks++;
        expect_item(1, 8'h00, "R1 oe in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        pin_in = 8'h00;
        rd(8'h01, 8'h00, "R1 dir after reset");

        tick();
        tick();
        done = 1;
        report();
    end
endmodule